// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside the receive byte stream of an Ethernet port. It inspects the first six bytes of each frame, which form the 48-bit destination address. Once the sixth byte has been taken it issues a one-cycle decision saying whether the frame should be kept. The block only observes the stream. Buffering, CRC checking and discarding the frame are left to the logic that consumes the decision.

Software loads the filter through 32-bit configuration writes. It provides one station (unicast) address, a table of four multicast addresses, and a mode register whose top bit switches the filter to accept everything. A multicast entry is loaded in two writes. The first write parks four address bytes in a staging register. The second write supplies the last two bytes and, in its upper half, the index of the table slot to fill. Only that second write commits the entry and marks it valid.

The byte stream uses a valid/ready handshake. The filter never applies back-pressure, so `s_ready` is held high and a byte counts as taken on every cycle where `s_valid` is high. Cycles where `s_valid` is low are gaps and do not advance the address capture. The producer may insert such gaps anywhere in a frame.

Top module: `rx_dafilt_top`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are low, `s_ready` is high, and every multicast entry is invalid. The station address resets to all zeros and promiscuous mode is off.
- R2: The station address is written at offset 0x380 and offset 0x384. The write to 0x380 carries address bytes 0..3, with byte 0 (first on the wire) in bits 7:0 and byte 3 in bits 31:24. The write to 0x384 carries byte 4 in bits 7:0 and byte 5 in bits 15:8. A frame whose destination equals this address is accepted, and a frame with the bytes in any other order is not.
- R3: A frame whose destination is all ones (FF:FF:FF:FF:FF:FF) is always accepted.
- R4: A write to 0x38C commits a multicast entry. That entry uses the staged bytes 0..3, byte 4 from bits 7:0, byte 5 from bits 15:8, and the table index from bits 17:16. The entry becomes valid, and a frame matching any valid entry is accepted. Valid bits are only ever set; they are cleared by reset alone.
- R5: A write to 0x388 only loads the staging register, with bytes 0..3 in the same order as R2. It alters no table entry by itself.
- R6: A frame matching no station address, no valid multicast entry and not broadcast is rejected when promiscuous mode is off. An invalid table slot never matches.
- R7: Bit 31 of the mode register at 0x390 turns promiscuous mode on, and every frame is then accepted. All other bits of that register have no effect.
- R8: `dec_valid` pulses high for exactly one cycle, in the cycle after the sixth address byte is taken, once per frame. `dec_accept` is only high while `dec_valid` is high.
- R9: A byte with `s_sof` high starts a new address capture, even in the middle of a previous one. Bytes after the sixth byte of a frame produce no further decision until the next `s_sof`.
- R10: If a configuration write lands in the same cycle as the sixth address byte, the decision for that frame uses the configuration as it was before the write. The write takes effect for the next frame.
- R11: Rewriting a table index replaces that entry only. Other entries keep matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Stream byte is present |
| s_ready | output | 1 | Filter takes bytes; always high |
| s_sof | input | 1 | Marks the first byte of a frame |
| s_data | input | 8 | Stream byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| dec_valid | output | 1 | Decision strobe, one cycle per frame |
| dec_accept | output | 1 | Frame is kept (qualified by dec_valid) |

## Verification
A configuration write and the sixth address byte can arrive in the same cycle, so the filter update and the address comparison collide. The bench provokes this by writing a new station address, and separately by setting promiscuous mode, on exactly the cycle that completes a frame's address. The decision for that frame must follow the old settings, and a repeat of the same frame right after must follow the new ones.

// File: rtl/rx_dafilt_pkg.sv
package rx_dafilt_pkg;
  localparam int MAC_BYTES = 6;
  localparam int MAC_W     = 8 * MAC_BYTES;
  localparam int CFG_DW    = 32;

  localparam logic [11:0] OFS_UC_LO = 12'h380;
  localparam logic [11:0] OFS_UC_HI = 12'h384;
  localparam logic [11:0] OFS_MC_LO = 12'h388;
  localparam logic [11:0] OFS_MC_HI = 12'h38C;
  localparam logic [11:0] OFS_MODE  = 12'h390;

  localparam int MODE_PROMISC_BIT = 31;
  localparam int MC_IDX_LSB       = 16;

  typedef logic [MAC_W-1:0] mac_t;
endpackage

// File: rtl/rx_dafilt_cfg.sv
module rx_dafilt_cfg
  import rx_dafilt_pkg::*;
#(
  parameter int NUM_MC = 4,
  parameter int CFG_AW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [CFG_AW-1:0]    addr,
  input  logic [CFG_DW-1:0]    wdata,
  output mac_t                 uc_addr,
  output mac_t                 mc_addr [NUM_MC],
  output logic [NUM_MC-1:0]    mc_vld,
  output logic                 promisc
);
  localparam int IDXW = (NUM_MC > 1) ? $clog2(NUM_MC) : 1;

  logic [CFG_DW-1:0] stage_q;
  logic              wr_uc_lo, wr_uc_hi, wr_mc_lo, wr_mc_hi, wr_mode;
  logic [IDXW-1:0]   wr_idx;

  assign wr_uc_lo = we && (addr == CFG_AW'(OFS_UC_LO));
  assign wr_uc_hi = we && (addr == CFG_AW'(OFS_UC_HI));
  assign wr_mc_lo = we && (addr == CFG_AW'(OFS_MC_LO));
  assign wr_mc_hi = we && (addr == CFG_AW'(OFS_MC_HI));
  assign wr_mode  = we && (addr == CFG_AW'(OFS_MODE));
  assign wr_idx   = wdata[MC_IDX_LSB +: IDXW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uc_addr <= '0;
      stage_q <= '0;
      promisc <= 1'b0;
    end else begin
      if (wr_uc_lo) uc_addr[31:0]  <= wdata;
      if (wr_uc_hi) uc_addr[47:32] <= wdata[15:0];
      if (wr_mc_lo) stage_q        <= wdata;
      if (wr_mode)  promisc        <= wdata[MODE_PROMISC_BIT];
    end
  end

  for (genvar g = 0; g < NUM_MC; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mc_addr[g] <= '0;
        mc_vld[g]  <= 1'b0;
      end else if (wr_mc_hi && (wr_idx == IDXW'(g))) begin
        mc_addr[g] <= {wdata[15:0], stage_q};
        mc_vld[g]  <= 1'b1;
      end
    end
  end

  AST_VLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(mc_vld) & ~mc_vld) == '0)); // R4

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mc_lo |=> $stable(stage_q)); // R5
endmodule

// File: rtl/rx_dafilt_hdr.sv
module rx_dafilt_hdr
  import rx_dafilt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic       sof,
  input  logic [7:0] data,
  output logic       fire,
  output mac_t       dst
);
  localparam int CW   = $clog2(MAC_BYTES + 1);
  localparam int LAST = MAC_BYTES - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] pos;
  logic [7:0]    hold_q [LAST];

  assign pos  = sof ? '0 : cnt_q;
  assign fire = beat && (pos == CW'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(MAC_BYTES);
    end else if (beat && (pos < CW'(MAC_BYTES))) begin
      cnt_q <= pos + 1'b1;
    end
  end

  for (genvar g = 0; g < LAST; g++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q[g] <= '0;
      else if (beat && (pos == CW'(g))) hold_q[g] <= data;
    end
    assign dst[8*g +: 8] = hold_q[g];
  end
  assign dst[8*LAST +: 8] = data;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == CW'(MAC_BYTES))); // R9
endmodule

// File: rtl/rx_dafilt_match.sv
module rx_dafilt_match
  import rx_dafilt_pkg::*;
#(
  parameter int NUM_MC = 4
) (
  input  mac_t              dst,
  input  mac_t              uc_addr,
  input  mac_t              mc_addr [NUM_MC],
  input  logic [NUM_MC-1:0] mc_vld,
  input  logic              promisc,
  output logic              keep
);
  logic [NUM_MC-1:0] mc_hit;
  logic              uc_hit, bc_hit;

  for (genvar g = 0; g < NUM_MC; g++) begin : g_cmp
    assign mc_hit[g] = mc_vld[g] && (dst == mc_addr[g]);
  end

  assign uc_hit = (dst == uc_addr);
  assign bc_hit = &dst;
  assign keep   = promisc || uc_hit || bc_hit || (|mc_hit);
endmodule

// File: rtl/rx_dafilt_top.sv
module rx_dafilt_top
  import rx_dafilt_pkg::*;
#(
  parameter int NUM_MC = 4,
  parameter int CFG_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_sof,
  input  logic [7:0]        s_data,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              dec_valid,
  output logic              dec_accept
);
  mac_t              uc_addr;
  mac_t              mc_addr [NUM_MC];
  logic [NUM_MC-1:0] mc_vld;
  logic              promisc;
  logic              fire, keep, beat;
  mac_t              dst;

  assign s_ready = 1'b1;
  assign beat    = s_valid && s_ready;

  rx_dafilt_cfg #(.NUM_MC(NUM_MC), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .uc_addr(uc_addr), .mc_addr(mc_addr),
    .mc_vld(mc_vld), .promisc(promisc)
  );

  rx_dafilt_hdr u_hdr (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(s_sof),
    .data(s_data), .fire(fire), .dst(dst)
  );

  rx_dafilt_match #(.NUM_MC(NUM_MC)) u_match (
    .dst(dst), .uc_addr(uc_addr), .mc_addr(mc_addr),
    .mc_vld(mc_vld), .promisc(promisc), .keep(keep)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= fire;
      dec_accept <= fire && keep;
    end
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R8

  AST_ACC_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept); // R8

  AST_PROMISC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(promisc)) |-> dec_accept); // R7
endmodule

// File: tb/tb_rx_dafilt_top.sv
module tb_rx_dafilt_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_sof = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        dec_valid, dec_accept;
  int          total = 0, bad = 0;

  always #2.5 clk = ~clk;

  rx_dafilt_top dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_sof(s_sof), .s_data(s_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  // Frame addresses written with wire byte 0 in bits 47:40.
  localparam logic [47:0] A_UC  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] A_MC2 = 48'h01_00_5E_00_00_FB;
  localparam logic [47:0] A_MC1 = 48'h01_80_C2_00_00_0E;
  localparam logic [47:0] A_MC2B= 48'h33_33_00_00_00_01;
  localparam logic [47:0] A_BC  = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] A_OTH = 48'h0A_0B_0C_0D_0E_0F;

  // {address, expected accept}
  localparam logic [48:0] VEC [6] = '{
    {A_UC,  1'b1},                     // R2
    {A_BC,  1'b1},                     // R3
    {A_MC2, 1'b1},                     // R4
    {A_OTH, 1'b0},                     // R6
    {48'h02_11_22_33_44_54, 1'b0},     // R6
    {48'h55_44_33_22_11_02, 1'b0}      // R2 reversed order
  };

  function automatic logic [7:0] bt(input logic [47:0] a, input int i);
    return a[47-8*i -: 8];
  endfunction
  function automatic logic [31:0] lo_word(input logic [47:0] a);
    return {bt(a,3), bt(a,2), bt(a,1), bt(a,0)};
  endfunction
  function automatic logic [15:0] hi_half(input logic [47:0] a);
    return {bt(a,5), bt(a,4)};
  endfunction

  task automatic check(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic cfg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Sends six address bytes; optional config write on the sixth byte.
  task automatic frame(input logic [47:0] a, input logic exp, input string tag,
                       input logic cw, input logic [11:0] ca, input logic [31:0] cd);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_sof = (i == 0); s_data = bt(a, i);
      cfg_we = cw && (i == 5); cfg_addr = ca; cfg_wdata = cd;
      if (i < 5) check(dec_valid, 1'b0, {tag, " early"});
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; cfg_we = 1'b0;
    check(dec_valid, 1'b1, {tag, " R8 valid"});
    check(dec_accept, exp, tag);
    @(negedge clk);
    check(dec_valid, 1'b0, {tag, " R8 single pulse"});
  endtask

  initial begin
    #(5 * 100000);
    bad++; total++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dec_valid, 1'b0, "R1 reset valid");
    check(dec_accept, 1'b0, "R1 reset accept");
    check(s_ready, 1'b1, "R1 ready");
    rst_n = 1'b1;
    @(negedge clk);
    frame(A_MC2, 1'b0, "R1 empty table", 1'b0, '0, '0);
    frame(48'h0, 1'b1, "R1 station zero", 1'b0, '0, '0);

    cfg_wr(12'h380, lo_word(A_UC));
    cfg_wr(12'h384, {16'h0, hi_half(A_UC)});
    cfg_wr(12'h388, lo_word(A_MC2));
    cfg_wr(12'h38C, {14'h0, 2'd2, hi_half(A_MC2)});

    foreach (VEC[k]) frame(VEC[k][48:1], VEC[k][0], $sformatf("vec%0d", k), 1'b0, '0, '0);

    // R5 staging alone does nothing
    cfg_wr(12'h388, lo_word(A_MC1));
    frame(A_MC1, 1'b0, "R5 staged only", 1'b0, '0, '0);
    cfg_wr(12'h38C, {14'h0, 2'd1, hi_half(A_MC1)});
    frame(A_MC1, 1'b1, "R4 committed idx1", 1'b0, '0, '0);

    // R11 overwrite idx2
    cfg_wr(12'h388, lo_word(A_MC2B));
    cfg_wr(12'h38C, {14'h0, 2'd2, hi_half(A_MC2B)});
    frame(A_MC2, 1'b0, "R11 old entry gone", 1'b0, '0, '0);
    frame(A_MC2B, 1'b1, "R11 new entry", 1'b0, '0, '0);
    frame(A_MC1, 1'b1, "R11 other entry kept", 1'b0, '0, '0);

    // R7 promiscuous
    cfg_wr(12'h390, 32'h7FFF_FFFF);
    frame(A_OTH, 1'b0, "R7 low bits ignored", 1'b0, '0, '0);
    cfg_wr(12'h390, 32'h8000_0000);
    frame(A_OTH, 1'b1, "R7 promisc", 1'b0, '0, '0);
    cfg_wr(12'h390, 32'h0);
    frame(A_OTH, 1'b0, "R7 promisc off", 1'b0, '0, '0);

    // R9 restart mid-capture, then trailing bytes without sof
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_sof = (i == 0); s_data = 8'hEE;
    end
    frame(A_UC, 1'b1, "R9 restart", 1'b0, '0, '0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_sof = 1'b0; s_data = 8'hFF;
      if (i > 0) check(dec_valid, 1'b0, "R9 no decision without sof");
    end
    @(negedge clk); s_valid = 1'b0;
    check(dec_valid, 1'b0, "R9 no decision without sof");

    // R10 collisions
    frame(A_UC, 1'b1, "R10 old station", 1'b1, 12'h380, 32'h0);
    frame(A_UC, 1'b0, "R10 new station", 1'b0, '0, '0);
    frame(A_OTH, 1'b0, "R10 old mode", 1'b1, 12'h390, 32'h8000_0000);
    frame(A_OTH, 1'b1, "R10 new mode", 1'b0, '0, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule